// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder

This block is the device-side control of an extended-data-out DRAM with an 8-bit data port. A fast clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable). The block compares each sample with the one before it to find strobe edges, and the order of those edges decides the kind of cycle. It latches row and column addresses, drives read, write and refresh strokes to a behavioural memory array outside the block, and holds read data on the port after the column strobe has risen.

Refresh comes in three forms. A row-only cycle refreshes the row on the address pins. A column-before-row cycle, and a hidden refresh that follows a read, both refresh the row held in an internal counter. A diagnostic output gives the most recently decoded cycle as a small code, so a bench can follow the classification.

Top module: `edo_strobe_decoder`

## Requirements
- R1: After reset, and one clock after any sample with both row and column strobes high, `dOe` is low. When two consecutive samples have both strobes high, `cycleType` reads 0 (standby).
- R2: If write enable is already low when the column strobe falls in an open row, `dIn` is written to the latched row and column. `cycleType` becomes 2 (early write), and `dOe` stays low for the whole cycle.
- R3: A column strobe fall with write enable high starts a read of the latched row and column, and `cycleType` becomes 1 (read) when it is the first column of the row. The stored byte appears on `dOut` with `dOe` high within four clocks while output enable is low.
- R4: When the column strobe rises and the row strobe stays low, the read byte stays on `dOut` with `dOe` high.
- R5: Each later column strobe fall in the same open row reads the new column from the same row. With write enable high, `cycleType` becomes 5 (page).
- R6: Raising output enable turns `dOe` off, and lowering it again brings the held data back. A write-enable low pulse turns `dOe` off until the next read.
- R7: If write enable falls after the column strobe while the outputs are not driving, `dIn` is written to the latched location, `cycleType` becomes 3 (late write), and `dOe` stays low.
- R8: If write enable falls after the column strobe while the outputs are driving the old byte, `dIn` is written, `cycleType` becomes 4 (read-modify-write), and `dOe` goes low.
- R9: If the column strobe is already low when the row strobe falls and no read data is held, the row in the refresh counter is refreshed. The address pins are ignored, `dOe` stays low, and `cycleType` becomes 7.
- R10: A row-strobe low period with no column strobe fall refreshes the latched address row when the row strobe rises. `cycleType` becomes 6, and the refresh counter does not change.
- R11: When the row strobe rises and falls again while the column strobe stays low after a read, the counter row is refreshed, `cycleType` becomes 8 (hidden refresh), and the read byte stays on `dOut` with `dOe` high.
- R12: The refresh counter starts at 0 after reset. It advances by one after each counter-based refresh (R9, R11) and wraps after 2048 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W (11) | Multiplexed row/column address |
| dIn | input | DATA_W (8) | Write data from the port |
| dOut | output | DATA_W (8) | Read data, valid while dOe is high |
| dOe | output | 1 | Port output drive enable |
| memRd | output | 1 | Array read strobe |
| memWr | output | 1 | Array write strobe |
| memRef | output | 1 | Array row refresh strobe |
| memRow | output | ROW_W (11) | Array row (counter row during counter-based refresh) |
| memCol | output | COL_W (10) | Array column |
| memWdata | output | DATA_W (8) | Array write data |
| memRdata | input | DATA_W (8) | Array read data, combinational from memRow/memCol |
| cycleType | output | 4 | Code of the last decoded cycle |

## Verification
Suppose the block keeps stale open-row or write-done state. A later edge of write enable would then write to memory when it should not, or the cycle would be reported as the wrong type. Either shows at the memory strobes or on `cycleType` one clock after the edge that caused it. A wrong held-data flag shows up differently. The output stays driven, or stays dark, across column strobe rises, output-enable toggles and hidden refreshes, and `dOe` shows this two clocks later. A refresh counter that has drifted reports the wrong row on the very next counter-based refresh. The bench therefore predicts the expected counter row for every refresh, including across a full wrap.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

  typedef enum logic [3:0] {
    CT_STANDBY = 4'd0,
    CT_READ    = 4'd1,
    CT_EARLY   = 4'd2,
    CT_LATE    = 4'd3,
    CT_RMW     = 4'd4,
    CT_PAGE    = 4'd5,
    CT_ROWREF  = 4'd6,
    CT_CBR     = 4'd7,
    CT_HIDDEN  = 4'd8
  } cycle_e;

  // One-clock commands from control to datapath
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic doRead;
    logic doWrite;
    logic doCbr;
    logic doRowRef;
    logic dropData;
    logic outAllowed;
  } ctl_strobes_t;

endpackage

// File: rtl/edo_dec_ctrl.sv
module edo_dec_ctrl
  import edo_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  input  logic         oeN,
  input  logic         dataHeld,
  input  logic         outDriving,
  output ctl_strobes_t strobes,
  output cycle_e       cycleType
);

  logic rasPrev, casPrev, wePrev;
  logic inAccess, colSeen, casWrote;

  logic rasFall, rasRise, casFall, weFall, bothHigh;
  logic cbrStart, accessCas, lateWe, rowOnly;

  always_comb begin
    rasFall   = rasPrev & ~rasN;
    rasRise   = ~rasPrev & rasN;
    casFall   = casPrev & ~casN;
    weFall    = wePrev & ~weN;
    bothHigh  = rasN & casN;
    cbrStart  = rasFall & ~casPrev & ~casN;
    accessCas = casFall & inAccess & ~rasN;
    lateWe    = weFall & inAccess & ~rasN & ~casN & ~casFall & colSeen & ~casWrote;
    rowOnly   = rasRise & inAccess & ~colSeen;

    strobes            = '0;
    strobes.latchRow   = rasFall & casPrev;
    strobes.latchCol   = accessCas;
    strobes.doRead     = accessCas & weN;
    strobes.doWrite    = (accessCas & ~weN) | lateWe;
    strobes.doCbr      = cbrStart;
    strobes.doRowRef   = rowOnly;
    strobes.dropData   = bothHigh | weFall | (accessCas & ~weN);
    strobes.outAllowed = ~oeN & weN & ~bothHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasPrev   <= 1'b1;
      casPrev   <= 1'b1;
      wePrev    <= 1'b1;
      inAccess  <= 1'b0;
      colSeen   <= 1'b0;
      casWrote  <= 1'b0;
      cycleType <= CT_STANDBY;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      wePrev  <= weN;

      if (rasFall && casPrev) begin
        inAccess <= 1'b1;
        colSeen  <= 1'b0;
      end else if (rasRise) begin
        inAccess <= 1'b0;
      end

      if (accessCas) begin
        colSeen  <= 1'b1;
        casWrote <= ~weN;
      end else if (lateWe) begin
        casWrote <= 1'b1;
      end

      if (rasPrev && casPrev && bothHigh)
        cycleType <= CT_STANDBY;
      else if (cbrStart)
        cycleType <= dataHeld ? CT_HIDDEN : CT_CBR;
      else if (rowOnly)
        cycleType <= CT_ROWREF;
      else if (accessCas)
        cycleType <= !weN ? CT_EARLY : (colSeen ? CT_PAGE : CT_READ);
      else if (lateWe)
        cycleType <= outDriving ? CT_RMW : CT_LATE;
    end
  end

endmodule

// File: rtl/edo_dec_datapath.sv
module edo_dec_datapath
  import edo_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  output logic              memRef,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              dataHeld
);

  logic [ROW_W-1:0]  rowReg, refRowReg, refCnt;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] outData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg    <= '0;
      colReg    <= '0;
      refRowReg <= '0;
      refCnt    <= '0;
      outData   <= '0;
      memWdata  <= '0;
      memRd     <= 1'b0;
      memWr     <= 1'b0;
      memRef    <= 1'b0;
      dataHeld  <= 1'b0;
      dOe       <= 1'b0;
    end else begin
      if (strobes.latchRow) rowReg <= addr[ROW_W-1:0];
      if (strobes.latchCol) colReg <= addr[COL_W-1:0];
      if (strobes.doWrite)  memWdata <= dIn;

      memRd  <= strobes.doRead;
      memWr  <= strobes.doWrite;
      memRef <= strobes.doCbr | strobes.doRowRef;

      if (strobes.doCbr) begin
        refRowReg <= refCnt;
        refCnt    <= refCnt + 1'b1;
      end else if (strobes.doRowRef) begin
        refRowReg <= rowReg;
      end

      if (memRd) outData <= memRdata;

      if (strobes.dropData)
        dataHeld <= 1'b0;
      else if (memRd)
        dataHeld <= 1'b1;

      dOe <= strobes.outAllowed & dataHeld;
    end
  end

  assign memRow = memRef ? refRowReg : rowReg;
  assign memCol = colReg;
  assign dOut   = dOe ? outData : '0;

endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
  import edo_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              memRd,
  output logic              memWr,
  output logic              memRef,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [3:0]        cycleType
);

  ctl_strobes_t strobes;
  cycle_e       ctType;
  logic         dataHeld;

  edo_dec_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .oeN        (oeN),
    .dataHeld   (dataHeld),
    .outDriving (dOe),
    .strobes    (strobes),
    .cycleType  (ctType)
  );

  edo_dec_datapath #(
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addr     (addr),
    .dIn      (dIn),
    .memRdata (memRdata),
    .memRd    (memRd),
    .memWr    (memWr),
    .memRef   (memRef),
    .memRow   (memRow),
    .memCol   (memCol),
    .memWdata (memWdata),
    .dOut     (dOut),
    .dOe      (dOe),
    .dataHeld (dataHeld)
  );

  assign cycleType = ctType;

endmodule

// File: rtl/edo_dec_checker.sv
module edo_dec_checker #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic              oeN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dIn,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe,
  input logic              memRd,
  input logic              memWr,
  input logic              memRef,
  input logic [ROW_W-1:0]  memRow,
  input logic [COL_W-1:0]  memCol,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] memRdata,
  input logic [3:0]        cycleType
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && casN) |=> !dOe); // R1

  AST_WRITE_UNDER_CAS: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(!casN)); // R2

  AST_EARLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 4'd2) |-> !dOe); // R2

  AST_LATE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 4'd3) |-> !dOe); // R7

  AST_RMW_FROM_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 4'd4 && $past(cycleType) != 4'd4) |-> $past(dOe)); // R8

  AST_CBR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 4'd7) |-> !dOe); // R9

  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, memRef})); // R10

endmodule

bind edo_strobe_decoder edo_dec_checker #(
  .DATA_W (DATA_W),
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/edo_strobe_decoder_tb_top.sv
module edo_strobe_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 11;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rasN, casN, weN, oeN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dIn;
  logic [DATA_W-1:0] dOut;
  logic              dOe;
  logic              memRd, memWr, memRef;
  logic [ROW_W-1:0]  memRow;
  logic [COL_W-1:0]  memCol;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;
  logic [3:0]        cycleType;

  int nChecks = 0;
  int nFail   = 0;
  logic [ROW_W-1:0] expRef = '0;
  logic [ROW_W-1:0] lastRef = '0;

  // Small behavioural array: 32 rows x 32 columns are enough here
  logic [DATA_W-1:0] memModel [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_strobe_decoder dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe),
    .memRd(memRd), .memWr(memWr), .memRef(memRef),
    .memRow(memRow), .memCol(memCol), .memWdata(memWdata),
    .memRdata(memRdata), .cycleType(cycleType)
  );

  assign memRdata = memModel[{memRow[4:0], memCol[4:0]}];

  always @(posedge clk) begin
    if (memWr)  memModel[{memRow[4:0], memCol[4:0]}] <= memWdata;
    if (memRef) lastRef <= memRow;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] peek(input int row, input int col);
    return memModel[{row[4:0], col[4:0]}];
  endfunction

  task automatic go_idle();
    rasN = 1'b1; casN = 1'b1; weN = 1'b1; oeN = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    check("R1", "dOe after reset", dOe, 1'b0);
    check("R1", "type after reset", cycleType, 4'd0);
    check("R12", "no refresh at reset", lastRef, '0);
  endtask

  task automatic t_early_write(input int row, input int col, input logic [7:0] data);
    addr = ADDR_W'(row); rasN = 1'b0; tick(2);
    weN = 1'b0; dIn = data; tick(1);
    addr = ADDR_W'(col); casN = 1'b0; tick(1);
    check("R2", "early write type", cycleType, 4'd2);
    check("R2", "early write dOe", dOe, 1'b0);
    tick(2);
    check("R2", "early write dOe later", dOe, 1'b0);
    go_idle();
    check("R2", "early write stored", peek(row, col), data);
  endtask

  task automatic t_read_page_hold();
    addr = 11'd5; rasN = 1'b0; tick(2);
    oeN = 1'b0; addr = 11'd3; casN = 1'b0; tick(1);
    check("R3", "read type", cycleType, 4'd1);
    tick(3);
    check("R3", "read dOe", dOe, 1'b1);
    check("R3", "read data", dOut, 8'hA5);
    casN = 1'b1; tick(3);
    check("R4", "hold dOe after cas rise", dOe, 1'b1);
    check("R4", "hold data after cas rise", dOut, 8'hA5);
    addr = 11'd4; casN = 1'b0; tick(1);
    check("R5", "page type", cycleType, 4'd5);
    tick(3);
    check("R5", "page data", dOut, 8'h3C);
    oeN = 1'b1; tick(2);
    check("R6", "oe high turns off", dOe, 1'b0);
    oeN = 1'b0; tick(2);
    check("R6", "oe low restores", dOut, 8'h3C);
    casN = 1'b1; tick(2);
    weN = 1'b0; tick(1); weN = 1'b1; tick(3);
    check("R6", "we pulse turns off", dOe, 1'b0);
    check("R6", "we pulse no write", peek(5, 4), 8'h3C);
    rasN = 1'b1; tick(2);
    check("R1", "standby dOe", dOe, 1'b0);
    check("R1", "standby type", cycleType, 4'd0);
    go_idle();
  endtask

  task automatic t_late_write();
    addr = 11'd7; rasN = 1'b0; tick(2);
    addr = 11'd1; casN = 1'b0; tick(2);
    dIn = 8'h5A; weN = 1'b0; tick(1);
    check("R7", "late write type", cycleType, 4'd3);
    tick(2);
    check("R7", "late write dOe", dOe, 1'b0);
    go_idle();
    check("R7", "late write stored", peek(7, 1), 8'h5A);
  endtask

  task automatic t_rmw();
    addr = 11'd7; rasN = 1'b0; tick(2);
    oeN = 1'b0; addr = 11'd1; casN = 1'b0; tick(4);
    check("R8", "rmw old data driven", dOut, 8'h5A);
    dIn = 8'hC3; weN = 1'b0; tick(1);
    check("R8", "rmw type", cycleType, 4'd4);
    tick(1);
    check("R8", "rmw dOe off", dOe, 1'b0);
    go_idle();
    check("R8", "rmw stored", peek(7, 1), 8'hC3);
  endtask

  task automatic t_cbr(input bit doCheck);
    casN = 1'b0; tick(2);
    addr = 11'h7FF; rasN = 1'b0; tick(1);
    if (doCheck) check("R9", "cbr type", cycleType, 4'd7);
    tick(1);
    if (doCheck) begin
      check("R9", "cbr row from counter", lastRef, expRef);
      check("R9", "cbr dOe", dOe, 1'b0);
    end
    expRef = expRef + 1'b1;
    rasN = 1'b1; casN = 1'b1; tick(2);
  endtask

  task automatic t_row_only();
    addr = 11'h123; rasN = 1'b0; tick(3);
    rasN = 1'b1; tick(1);
    check("R10", "row-only type", cycleType, 4'd6);
    tick(1);
    check("R10", "row-only refreshed row", lastRef, 11'h123);
    tick(2);
    t_cbr(1'b1);
  endtask

  task automatic t_hidden();
    addr = 11'd5; rasN = 1'b0; tick(2);
    oeN = 1'b0; addr = 11'd3; casN = 1'b0; tick(4);
    rasN = 1'b1; tick(3);
    check("R11", "data kept across ras rise", dOut, 8'hA5);
    addr = 11'h456; rasN = 1'b0; tick(1);
    check("R11", "hidden type", cycleType, 4'd8);
    tick(1);
    check("R11", "hidden row from counter", lastRef, expRef);
    expRef = expRef + 1'b1;
    tick(2);
    check("R11", "hidden dOe", dOe, 1'b1);
    check("R11", "hidden data", dOut, 8'hA5);
    go_idle();
  endtask

  task automatic t_wrap();
    while (expRef != '0) t_cbr(1'b0);
    t_cbr(1'b1);
    check("R12", "counter wrapped to row 0", lastRef, '0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) memModel[i] = '0;
    rstN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; oeN = 1'b1;
    addr = '0; dIn = '0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    t_reset();
    t_early_write(5, 3, 8'hA5);
    t_early_write(5, 4, 8'h3C);
    t_read_page_hold();
    t_late_write();
    t_rmw();
    t_cbr(1'b1);
    t_cbr(1'b1);
    t_row_only();
    t_hidden();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule